// File: doc/BRIEF.md
# CAN Fault Confinement Tracker

This block keeps the fault-confinement standing of one CAN node. The protocol engine reports what happened on the bus as single-cycle strobes: a receive error worth one or eight points, a transmit error worth eight points, and successful receptions or transmissions that each take one point back. The block keeps a receive error counter and a transmit error counter, and from them it decides whether the node may take full part on the bus (error-active), must signal errors more quietly (error-passive), or must keep off the bus entirely (bus-off).

Entering error-passive and leaving it use different limits, so the node does not bounce between the two states when a count sits at the boundary. Once bus-off, the node ignores every counter strobe and only watches the sampled bus bits. It counts complete runs of eleven recessive bits in a row. When enough runs have been seen, it clears both counters and goes back to error-active. Level warning flags and one-clock notification pulses go to an interrupt unit.

Top module: `can_fault_conf`

## Requirements
- R1: A synchronous active-high reset puts `node_state` at error-active (code 0), both counters at zero, and every warning flag and pulse low. `node_state` only ever takes codes 0 (error-active), 1 (error-passive) and 2 (bus-off).
- R2: The receive counter is 8 bits wide. When several receive strobes arrive in one cycle, `rx_err_add8` (+8) wins over `rx_err_add1` (+1), which wins over `rx_ok` (-1). Additions saturate at 255, and a decrement at zero leaves the count at zero.
- R3: The transmit counter is 9 bits wide. `tx_err_add8` (+8) wins over `tx_ok` (-1). Additions saturate at 511, and a decrement at zero leaves the count at zero.
- R4: From error-active, the node moves to error-passive on the same clock edge at which the receive or the transmit count becomes greater than 127. A count of exactly 127 keeps it error-active.
- R5: From error-passive, the node moves back to error-active only when both counts are below 127. With either count at exactly 127 it stays error-passive.
- R6: When the transmit count becomes greater than 255, the node enters bus-off on that same edge, whether it was error-active or error-passive.
- R7: While the node is bus-off, all five counter strobes are ignored and both counters keep their values.
- R8: While the node is bus-off, each cycle with `bit_valid` high samples one bus bit from `bit_recessive`. Eleven recessive samples in a row complete one run. A dominant sample throws away the partial run. When the 128th run completes, on that same edge both counters become zero and the node becomes error-active.
- R9: `rx_warn` and `tx_warn` are high exactly while the matching counter is 96 or more.
- R10: Each notification pulse is high for exactly the one cycle in which its condition first becomes true. The conditions are: receive warning, transmit warning, error-passive with receive count above 127, error-passive with transmit count above 127, and bus-off. `state_change_pulse` is high for one cycle whenever `node_state` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_err_add1 | input | 1 | Receive error, add one |
| rx_err_add8 | input | 1 | Receive error, add eight |
| rx_ok | input | 1 | Successful reception, subtract one |
| tx_err_add8 | input | 1 | Transmit error, add eight |
| tx_ok | input | 1 | Successful transmission, subtract one |
| bit_valid | input | 1 | A sampled bus bit is present this cycle |
| bit_recessive | input | 1 | Sampled bit is recessive (1) or dominant (0) |
| node_state | output | 2 | 0 error-active, 1 error-passive, 2 bus-off |
| rx_count | output | 8 | Receive error count |
| tx_count | output | 9 | Transmit error count |
| rx_warn | output | 1 | Receive count at 96 or more |
| tx_warn | output | 1 | Transmit count at 96 or more |
| rx_warn_pulse | output | 1 | Receive warning just asserted |
| tx_warn_pulse | output | 1 | Transmit warning just asserted |
| rx_passive_pulse | output | 1 | Error-passive due to receive count just asserted |
| tx_passive_pulse | output | 1 | Error-passive due to transmit count just asserted |
| busoff_pulse | output | 1 | Bus-off just entered |
| state_change_pulse | output | 1 | node_state changed |

## Verification
The assertions assume that the strobes are single-cycle events that may coincide in any combination, with priority settling the outcome. They also assume that bus bits count only while `bit_valid` is high, and that `bit_recessive` means nothing when it is low. The stimulus draws every strobe on its own each cycle, so coinciding strobes are common. It keeps on driving strobes while the node is bus-off, and it gives invalid cycles random bit values so that these are shown to be ignored. Directed phases walk the counts across the 127 boundary from both sides and push the transmit count past 255. The recovery bit stream mixes dominant bits in before it goes fully recessive.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

    typedef enum logic [1:0] {
        NODE_ACTIVE  = 2'd0,
        NODE_PASSIVE = 2'd1,
        NODE_BUSOFF  = 2'd2
    } node_state_e;

    // Level conditions that feed both the flag outputs and the edge pulses.
    typedef struct packed {
        logic rx_warn;
        logic tx_warn;
        logic rx_pas;
        logic tx_pas;
        logic boff;
    } cond_t;

    localparam int DEF_RX_W        = 8;
    localparam int DEF_TX_W        = 9;
    localparam int DEF_WARN_AT     = 96;
    localparam int DEF_PASS_ABOVE  = 127;
    localparam int DEF_BOFF_ABOVE  = 255;
    localparam int DEF_RUN_LEN     = 11;
    localparam int DEF_RUN_TOTAL   = 128;
    localparam int ERR_STEP        = 8;

    function automatic cond_t rise(input cond_t now_v, input cond_t was_v);
        return cond_t'(now_v & ~was_v);
    endfunction

endpackage

// File: rtl/cfc_err_counter.sv
module cfc_err_counter #(
    parameter int W        = 8,
    parameter int BIG_STEP = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         hold,
    input  logic         inc_big,
    input  logic         inc_small,
    input  logic         dec,
    output logic [W-1:0] q,
    output logic [W-1:0] d
);
    logic [W:0] sum_big;
    logic [W:0] sum_small;

    assign sum_big   = {1'b0, q} + (W+1)'(BIG_STEP);
    assign sum_small = {1'b0, q} + (W+1)'(1);

    always_comb begin
        d = q;
        if (clear) begin
            d = '0;
        end else if (!hold) begin
            if (inc_big)
                d = sum_big[W] ? '1 : sum_big[W-1:0];
            else if (inc_small)
                d = sum_small[W] ? '1 : sum_small[W-1:0];
            else if (dec && (q != '0))
                d = q - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // R7: frozen while the node is off the bus
    p_hold_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (hold && !clear) |=> $stable(q));

    // R2 (receive instance) and R3 (transmit instance): saturation at the top
    p_sat_top_r2: assert property (@(posedge clk) disable iff (rst)
        ((q == '1) && !clear && !dec) |=> (q == '1));

    // R2 / R3: no wrap below zero
    p_floor_zero_r3: assert property (@(posedge clk) disable iff (rst)
        ((q == '0) && !inc_big && !inc_small) |=> (q == '0));

endmodule

// File: rtl/cfc_recovery.sv
module cfc_recovery #(
    parameter int RUN_LEN   = 11,
    parameter int RUN_TOTAL = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic bit_valid,
    input  logic bit_recessive,
    output logic done
);
    localparam int RW = (RUN_LEN   > 2) ? $clog2(RUN_LEN)   : 1;
    localparam int SW = (RUN_TOTAL > 2) ? $clog2(RUN_TOTAL) : 1;

    logic [RW-1:0] run_q, run_d;
    logic [SW-1:0] seq_q, seq_d;
    logic          run_last, seq_last;

    assign run_last = (run_q == RW'(RUN_LEN - 1));
    assign seq_last = (seq_q == SW'(RUN_TOTAL - 1));

    always_comb begin
        run_d = run_q;
        seq_d = seq_q;
        done  = 1'b0;
        if (!armed) begin
            run_d = '0;
            seq_d = '0;
        end else if (bit_valid) begin
            if (!bit_recessive) begin
                run_d = '0;
            end else if (run_last) begin
                run_d = '0;
                if (seq_last) begin
                    done  = 1'b1;
                    seq_d = '0;
                end else begin
                    seq_d = seq_q + SW'(1);
                end
            end else begin
                run_d = run_q + RW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            seq_q <= '0;
        end else begin
            run_q <= run_d;
            seq_q <= seq_d;
        end
    end

    // R8: a partial run never reaches the run length
    p_run_bound_r8: assert property (@(posedge clk) disable iff (rst)
        (int'(run_q) < RUN_LEN));

    // R8: a dominant sample discards the partial run
    p_dominant_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (armed && bit_valid && !bit_recessive) |=> (run_q == '0));

    // R8: nothing is counted while the node is on the bus
    p_idle_clear_r8: assert property (@(posedge clk) disable iff (rst)
        !armed |=> ((run_q == '0) && (seq_q == '0)));

endmodule

// File: rtl/cfc_mode_fsm.sv
module cfc_mode_fsm
    import cfc_pkg::*;
#(
    parameter int RX_W       = 8,
    parameter int TX_W       = 9,
    parameter int WARN_AT    = 96,
    parameter int PASS_ABOVE = 127,
    parameter int BOFF_ABOVE = 255
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [RX_W-1:0] rx_d,
    input  logic [TX_W-1:0] tx_d,
    input  logic [RX_W-1:0] rx_q,
    input  logic [TX_W-1:0] tx_q,
    input  logic            recover_done,
    output node_state_e     state_q,
    output cond_t           cond_q,
    output cond_t           pulse_q,
    output logic            chg_q
);
    node_state_e state_d;
    cond_t       cond_d;
    logic        rx_over, tx_over, both_under, tx_off;

    assign rx_over    = int'(rx_d) > PASS_ABOVE;
    assign tx_over    = int'(tx_d) > PASS_ABOVE;
    assign both_under = (int'(rx_d) < PASS_ABOVE) && (int'(tx_d) < PASS_ABOVE);
    assign tx_off     = int'(tx_d) > BOFF_ABOVE;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NODE_ACTIVE: begin
                if (tx_off)                  state_d = NODE_BUSOFF;
                else if (rx_over || tx_over) state_d = NODE_PASSIVE;
            end
            NODE_PASSIVE: begin
                if (tx_off)          state_d = NODE_BUSOFF;
                else if (both_under) state_d = NODE_ACTIVE;
            end
            NODE_BUSOFF: begin
                if (recover_done) state_d = NODE_ACTIVE;
            end
            default: state_d = NODE_ACTIVE;
        endcase
    end

    always_comb begin
        cond_d.rx_warn = int'(rx_d) >= WARN_AT;
        cond_d.tx_warn = int'(tx_d) >= WARN_AT;
        cond_d.rx_pas  = (state_d == NODE_PASSIVE) && rx_over;
        cond_d.tx_pas  = (state_d == NODE_PASSIVE) && tx_over;
        cond_d.boff    = (state_d == NODE_BUSOFF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= NODE_ACTIVE;
            cond_q  <= '0;
            pulse_q <= '0;
            chg_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cond_q  <= cond_d;
            pulse_q <= rise(cond_d, cond_q);
            chg_q   <= (state_d != state_q);
        end
    end

    // R1: only the three defined codes
    p_legal_state_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q != node_state_e'(2'd3)));

    // R4: error-active means neither count is above the limit
    p_active_limit_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == NODE_ACTIVE) |->
            ((int'(rx_q) <= PASS_ABOVE) && (int'(tx_q) <= PASS_ABOVE)));

    // R5: error-passive is held while either count sits at the limit or above
    p_passive_hyst_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == NODE_PASSIVE) |->
            ((int'(rx_q) >= PASS_ABOVE) || (int'(tx_q) >= PASS_ABOVE)));

    // R6: bus-off always carries a transmit count past the bus-off limit
    p_busoff_count_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == NODE_BUSOFF) |-> (int'(tx_q) > BOFF_ABOVE));

    // R10: bus-off and state-change notifications last one cycle
    p_pulse_single_r10: assert property (@(posedge clk) disable iff (rst)
        (pulse_q.boff || chg_q) |=> !pulse_q.boff);

endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
    import cfc_pkg::*;
#(
    parameter int RX_W       = DEF_RX_W,
    parameter int TX_W       = DEF_TX_W,
    parameter int WARN_AT    = DEF_WARN_AT,
    parameter int PASS_ABOVE = DEF_PASS_ABOVE,
    parameter int BOFF_ABOVE = DEF_BOFF_ABOVE,
    parameter int RUN_LEN    = DEF_RUN_LEN,
    parameter int RUN_TOTAL  = DEF_RUN_TOTAL
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rx_err_add1,
    input  logic            rx_err_add8,
    input  logic            rx_ok,
    input  logic            tx_err_add8,
    input  logic            tx_ok,
    input  logic            bit_valid,
    input  logic            bit_recessive,
    output logic [1:0]      node_state,
    output logic [RX_W-1:0] rx_count,
    output logic [TX_W-1:0] tx_count,
    output logic            rx_warn,
    output logic            tx_warn,
    output logic            rx_warn_pulse,
    output logic            tx_warn_pulse,
    output logic            rx_passive_pulse,
    output logic            tx_passive_pulse,
    output logic            busoff_pulse,
    output logic            state_change_pulse
);
    node_state_e     state_q;
    cond_t           cond_q, pulse_q;
    logic            chg_q;
    logic            off_bus, recover_done;
    logic [RX_W-1:0] rx_q, rx_d;
    logic [TX_W-1:0] tx_q, tx_d;

    assign off_bus = (state_q == NODE_BUSOFF);

    cfc_err_counter #(.W(RX_W), .BIG_STEP(ERR_STEP)) u_rx_cnt (
        .clk       (clk),
        .rst       (rst),
        .clear     (recover_done),
        .hold      (off_bus),
        .inc_big   (rx_err_add8),
        .inc_small (rx_err_add1),
        .dec       (rx_ok),
        .q         (rx_q),
        .d         (rx_d)
    );

    cfc_err_counter #(.W(TX_W), .BIG_STEP(ERR_STEP)) u_tx_cnt (
        .clk       (clk),
        .rst       (rst),
        .clear     (recover_done),
        .hold      (off_bus),
        .inc_big   (tx_err_add8),
        .inc_small (1'b0),
        .dec       (tx_ok),
        .q         (tx_q),
        .d         (tx_d)
    );

    cfc_recovery #(.RUN_LEN(RUN_LEN), .RUN_TOTAL(RUN_TOTAL)) u_recovery (
        .clk           (clk),
        .rst           (rst),
        .armed         (off_bus),
        .bit_valid     (bit_valid),
        .bit_recessive (bit_recessive),
        .done          (recover_done)
    );

    cfc_mode_fsm #(
        .RX_W       (RX_W),
        .TX_W       (TX_W),
        .WARN_AT    (WARN_AT),
        .PASS_ABOVE (PASS_ABOVE),
        .BOFF_ABOVE (BOFF_ABOVE)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .rx_d         (rx_d),
        .tx_d         (tx_d),
        .rx_q         (rx_q),
        .tx_q         (tx_q),
        .recover_done (recover_done),
        .state_q      (state_q),
        .cond_q       (cond_q),
        .pulse_q      (pulse_q),
        .chg_q        (chg_q)
    );

    assign node_state         = state_q;
    assign rx_count           = rx_q;
    assign tx_count           = tx_q;
    assign rx_warn            = cond_q.rx_warn;
    assign tx_warn            = cond_q.tx_warn;
    assign rx_warn_pulse      = pulse_q.rx_warn;
    assign tx_warn_pulse      = pulse_q.tx_warn;
    assign rx_passive_pulse   = pulse_q.rx_pas;
    assign tx_passive_pulse   = pulse_q.tx_pas;
    assign busoff_pulse       = pulse_q.boff;
    assign state_change_pulse = chg_q;

    // R9: warning flag agrees with the counter it watches
    p_warn_track_r9: assert property (@(posedge clk) disable iff (rst)
        (rx_warn == (int'(rx_count) >= WARN_AT)) && (tx_warn == (int'(tx_count) >= WARN_AT)));

    // R8: leaving bus-off finds both counters cleared
    p_recover_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (off_bus && recover_done) |=> ((rx_count == '0) && (tx_count == '0) && (node_state == 2'd0)));

endmodule

// File: tb/can_fault_conf_test.sv
module can_fault_conf_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a1 = 0, a8 = 0, rok = 0, t8 = 0, tok = 0, bv = 0, brec = 0;

    logic [1:0] node_state;
    logic [7:0] rx_count;
    logic [8:0] tx_count;
    logic rx_warn, tx_warn, rx_warn_pulse, tx_warn_pulse;
    logic rx_passive_pulse, tx_passive_pulse, busoff_pulse, state_change_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    // reference model state
    int m_rx = 0, m_tx = 0, m_st = 0, m_run = 0, m_seq = 0;
    bit m_lv[5];
    bit m_pu[5];
    bit m_chg = 0;

    always #2 clk = ~clk;

    can_fault_conf uut (
        .clk(clk), .rst(rst),
        .rx_err_add1(a1), .rx_err_add8(a8), .rx_ok(rok),
        .tx_err_add8(t8), .tx_ok(tok),
        .bit_valid(bv), .bit_recessive(brec),
        .node_state(node_state), .rx_count(rx_count), .tx_count(tx_count),
        .rx_warn(rx_warn), .tx_warn(tx_warn),
        .rx_warn_pulse(rx_warn_pulse), .tx_warn_pulse(tx_warn_pulse),
        .rx_passive_pulse(rx_passive_pulse), .tx_passive_pulse(tx_passive_pulse),
        .busoff_pulse(busoff_pulse), .state_change_pulse(state_change_pulse)
    );

    task automatic show_summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog expired (all requirements) actual=%0d cycles expected=done", cyc);
            show_summary();
            $finish;
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp = n_cmp + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic compare_all();
        check("R4 R5 R6 R8", "node_state", int'(node_state), m_st);
        check("R2 R7 R8", "rx_count", int'(rx_count), m_rx);
        check("R3 R7 R8", "tx_count", int'(tx_count), m_tx);
        check("R9", "rx_warn", int'(rx_warn), int'(m_lv[0]));
        check("R9", "tx_warn", int'(tx_warn), int'(m_lv[1]));
        check("R10", "rx_warn_pulse", int'(rx_warn_pulse), int'(m_pu[0]));
        check("R10", "tx_warn_pulse", int'(tx_warn_pulse), int'(m_pu[1]));
        check("R10", "rx_passive_pulse", int'(rx_passive_pulse), int'(m_pu[2]));
        check("R10", "tx_passive_pulse", int'(tx_passive_pulse), int'(m_pu[3]));
        check("R10", "busoff_pulse", int'(busoff_pulse), int'(m_pu[4]));
        check("R10", "state_change_pulse", int'(state_change_pulse), int'(m_chg));
    endtask

    // Advance the behavioural model by one clock using the driven inputs.
    task automatic model_step();
        bit done = 0;
        int ns;
        bit nl[5];
        if (m_st == 2) begin
            if (bv) begin
                if (!brec) m_run = 0;
                else if (m_run == 10) begin
                    m_run = 0;
                    if (m_seq == 127) begin done = 1; m_seq = 0; end
                    else m_seq = m_seq + 1;
                end else m_run = m_run + 1;
            end
        end else begin
            m_run = 0;
            m_seq = 0;
        end
        if (done) begin
            m_rx = 0;
            m_tx = 0;
        end else if (m_st != 2) begin
            if (a8)        m_rx = (m_rx + 8 > 255) ? 255 : m_rx + 8;
            else if (a1)   m_rx = (m_rx + 1 > 255) ? 255 : m_rx + 1;
            else if (rok && m_rx > 0) m_rx = m_rx - 1;
            if (t8)        m_tx = (m_tx + 8 > 511) ? 511 : m_tx + 8;
            else if (tok && m_tx > 0) m_tx = m_tx - 1;
        end
        ns = m_st;
        if (done) ns = 0;
        else if (m_st == 0) begin
            if (m_tx > 255) ns = 2;
            else if (m_rx > 127 || m_tx > 127) ns = 1;
        end else if (m_st == 1) begin
            if (m_tx > 255) ns = 2;
            else if (m_rx < 127 && m_tx < 127) ns = 0;
        end
        nl[0] = (m_rx >= 96);
        nl[1] = (m_tx >= 96);
        nl[2] = (ns == 1) && (m_rx > 127);
        nl[3] = (ns == 1) && (m_tx > 127);
        nl[4] = (ns == 2);
        for (int i = 0; i < 5; i++) begin
            m_pu[i] = nl[i] && !m_lv[i];
            m_lv[i] = nl[i];
        end
        m_chg = (ns != m_st);
        m_st  = ns;
    endtask

    // Drive one cycle of stimulus (called just after a falling edge).
    task automatic cycle(input bit i_a1, input bit i_a8, input bit i_rok,
                         input bit i_t8, input bit i_tok, input bit i_bv, input bit i_brec);
        a1 = i_a1; a8 = i_a8; rok = i_rok; t8 = i_t8; tok = i_tok; bv = i_bv; brec = i_brec;
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    function automatic bit pct(input int p);
        return ($urandom_range(0, 99) < p);
    endfunction

    task automatic rand_cycle(input int p_a1, input int p_a8, input int p_rok,
                              input int p_t8, input int p_tok, input int p_bv, input int p_rec);
        cycle(pct(p_a1), pct(p_a8), pct(p_rok), pct(p_t8), pct(p_tok), pct(p_bv), pct(p_rec));
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "node_state after reset", int'(node_state), 0);
        check("R1", "rx_count after reset", int'(rx_count), 0);
        check("R1", "tx_count after reset", int'(tx_count), 0);
        check("R1", "pulses after reset",
              int'({rx_warn, tx_warn, rx_warn_pulse, tx_warn_pulse, rx_passive_pulse,
                    tx_passive_pulse, busoff_pulse, state_change_pulse}), 0);
        rst = 1'b0;
        @(negedge clk);
        compare_all();

        // R4 / R5: directed walk across the 127 boundary on the receive side
        for (int i = 0; i < 15; i++) cycle(0, 1, 0, 0, 0, 0, 0);   // 120
        for (int i = 0; i < 7; i++)  cycle(1, 0, 0, 0, 0, 0, 0);   // 127
        check("R4", "still active at 127", int'(node_state), 0);
        cycle(1, 0, 0, 0, 0, 0, 0);                                 // 128
        check("R4", "passive above 127", int'(node_state), 1);
        cycle(0, 0, 1, 0, 0, 0, 0);                                 // 127
        check("R5", "passive held at 127", int'(node_state), 1);
        cycle(0, 0, 1, 0, 0, 0, 0);                                 // 126
        check("R5", "active below 127", int'(node_state), 0);
        // R2: priority with all three receive strobes together
        cycle(1, 1, 1, 0, 0, 0, 0);
        check("R2", "add8 wins priority", int'(rx_count), 134);

        // mixed random traffic, receive heavy
        for (int i = 0; i < 600; i++) rand_cycle(30, 25, 35, 10, 30, 50, 50);
        // drain back toward active
        for (int i = 0; i < 400; i++) rand_cycle(5, 2, 70, 3, 60, 50, 50);

        // R6: drive transmit errors until bus-off
        for (int i = 0; i < 400 && m_st != 2; i++) rand_cycle(10, 10, 10, 60, 10, 50, 50);
        check("R6", "reached bus-off", int'(node_state), 2);

        // R7 / R8: strobes ignored, bits with dominant interruptions
        for (int i = 0; i < 400; i++) rand_cycle(50, 50, 50, 50, 50, 80, 92);
        // R8: clean recessive stream until recovery
        for (int i = 0; i < 3000 && m_st == 2; i++) rand_cycle(50, 50, 50, 50, 50, 100, 100);
        check("R8", "recovered to active", int'(node_state), 0);
        check("R8", "rx cleared", int'(rx_count), 0);
        check("R8", "tx cleared", int'(tx_count), 0);

        // R3: saturation of the transmit counter is unreachable on the bus, so
        // push again to bus-off from a passive state and recover once more
        for (int i = 0; i < 20; i++) cycle(0, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 400 && m_st != 2; i++) rand_cycle(0, 0, 0, 70, 5, 0, 0);
        check("R6", "bus-off from passive", int'(node_state), 2);
        for (int i = 0; i < 3000 && m_st == 2; i++) rand_cycle(20, 20, 20, 20, 20, 60, 97);
        for (int i = 0; i < 3000 && m_st == 2; i++) rand_cycle(20, 20, 20, 20, 20, 100, 100);

        // final random soak
        for (int i = 0; i < 1500; i++) rand_cycle(20, 15, 40, 15, 40, 60, 60);

        show_summary();
        $finish;
    end

endmodule